// File: doc/BRIEF.md
# Peripheral Clock-Stop and Reset Control Bank

This block holds the clock-stop and reset state of up to 64 peripherals. Each of the two groups, resets and clock stops, is kept as two 32-bit words. A simple register bus changes each word without a read-modify-write. A write to a word's base address turns on the bits that are 1 in the data. A write to the same address plus 4 turns those bits off. Bits written as 0 keep their value.

The bank drives one reset line and one clock-enable line per peripheral. Any of the four words can be read back over the bus. A clock-stop bit normally means "stopped" when it is 1. A parameter mask marks bits with the opposite sense; by default this is bit 14 only. At reset every peripheral is held in reset. Every clock is stopped, except those named in a parameter mask of critical clocks, which start running.

The bus is single-cycle. A write takes effect at the clock edge where `req_i` and `we_i` are both high. Read data is combinational from `addr_i` while `req_i` is high and `we_i` is low, and is zero otherwise.

Top module: `clkrst_bank`

## Requirements
- R1: After `rst_ni` is released, every bit of `rst_o` is 1. `clk_en_o` equals the critical mask, by default bits 0, 5, 6 and 34.
- R2: A write to a word's set address (0x040 and 0x050 for resets, 0x080 and 0x090 for clock stops) sets to 1 every stored bit whose data bit is 1.
- R3: A write to set address + 4 (0x044, 0x054, 0x084, 0x094) clears to 0 every stored bit whose data bit is 1.
- R4: Data bits that are 0 in a set or clear write leave the matching stored bits unchanged.
- R5: Peripheral line i lives in the lower word (0x040 or 0x080) when i < 32 and in the upper word (0x050 or 0x090) otherwise, at bit position i mod 32.
- R6: A read of a set address or of its +4 clear address returns the word's current 32-bit stored state.
- R7: A stored clock-stop bit of 1 drives `clk_en_o` low, except at the inverted-sense bit 14, where a stored 1 drives `clk_en_o` high.
- R8: `rst_o[i]` equals the stored reset bit i, where 1 means the peripheral is held in reset.
- R9: A write to any other address changes no state, and a read of any other address returns zero.
- R10: No state changes on a cycle without a write strobe (`req_i` and `we_i` both high), reads included.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus and register clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Bus access strobe |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 12 | Byte address of the access |
| wdata_i | input | 32 | Write data, ones select bits |
| rdata_o | output | 32 | Read data (combinational) |
| rst_o | output | 64 | Per-peripheral reset, 1 = held |
| clk_en_o | output | 64 | Per-peripheral clock enable, 1 = running |

## Verification
The properties assume `addr_i`, `we_i` and `wdata_i` are stable and known whenever `req_i` is high at a clock edge. They also assume one access per cycle, so a set and a clear never hit the same word together. The bench changes bus inputs only on the falling edge. It drives a single access per cycle and picks random addresses from the mapped set plus a few unmapped and misaligned ones. It also issues idle and read-only cycles between writes, which exercises the hold behaviour.

// File: rtl/clkrst_bank_pkg.sv
package clkrst_bank_pkg;
  typedef enum logic [0:0] {GRP_RST = 1'b0, GRP_CLK = 1'b1} grp_e;
endpackage

// File: rtl/clkrst_sc_word.sv
module clkrst_sc_word #(
  parameter int unsigned WIDTH = 32,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             set_i,
  input  logic             clr_i,
  input  logic [WIDTH-1:0] mask_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] q_d;

  always_comb begin
    q_d = q_o;
    if (set_i) q_d = q_d | mask_i;
    if (clr_i) q_d = q_d & ~mask_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= RST_VAL;
    else         q_o <= q_d;
  end
endmodule

// File: rtl/clkrst_decode.sv
module clkrst_decode #(
  parameter int unsigned ADDR_W   = 12,
  parameter int unsigned N_WORDS  = 2,
  parameter logic [ADDR_W-1:0] RST_BASE = 12'h040,
  parameter logic [ADDR_W-1:0] CLK_BASE = 12'h080,
  parameter int unsigned WORD_STEP = 16,
  parameter int unsigned CLR_OFS   = 4
) (
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [2*N_WORDS-1:0] set_o,
  output logic [2*N_WORDS-1:0] clr_o,
  output logic [2*N_WORDS-1:0] rd_sel_o
);
  import clkrst_bank_pkg::*;
  localparam int unsigned NREG = 2 * N_WORDS;

  logic [NREG-1:0] hit_set, hit_clr;

  for (genvar g = 0; g < 2; g++) begin : g_grp
    localparam logic [ADDR_W-1:0] GBASE = (g == int'(GRP_RST)) ? RST_BASE : CLK_BASE;
    for (genvar w = 0; w < N_WORDS; w++) begin : g_word
      localparam logic [ADDR_W-1:0] SET_A = GBASE + ADDR_W'(w * WORD_STEP);
      localparam logic [ADDR_W-1:0] CLR_A = SET_A + ADDR_W'(CLR_OFS);
      assign hit_set[g*N_WORDS+w] = (addr_i == SET_A);
      assign hit_clr[g*N_WORDS+w] = (addr_i == CLR_A);
    end
  end

  assign set_o    = (req_i &&  we_i) ? hit_set : '0;
  assign clr_o    = (req_i &&  we_i) ? hit_clr : '0;
  assign rd_sel_o = (req_i && !we_i) ? (hit_set | hit_clr) : '0;
endmodule

// File: rtl/clkrst_bank.sv
module clkrst_bank #(
  parameter int unsigned N_LINES  = 64,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned ADDR_W   = 12,
  parameter logic [ADDR_W-1:0] RST_BASE = 12'h040,
  parameter logic [ADDR_W-1:0] CLK_BASE = 12'h080,
  parameter int unsigned WORD_STEP = 16,
  parameter int unsigned CLR_OFS   = 4,
  parameter logic [N_LINES-1:0] RUN_AT_RESET = 64'h0000_0004_0000_0061,
  parameter logic [N_LINES-1:0] INV_POL      = 64'h0000_0000_0000_4000
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_i,
  input  logic               we_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [DATA_W-1:0]  wdata_i,
  output logic [DATA_W-1:0]  rdata_o,
  output logic [N_LINES-1:0] rst_o,
  output logic [N_LINES-1:0] clk_en_o
);
  import clkrst_bank_pkg::*;
  localparam int unsigned N_WORDS = N_LINES / DATA_W;
  localparam int unsigned NREG    = 2 * N_WORDS;
  // stored stop value giving the requested run state at reset
  localparam logic [N_LINES-1:0] STOP_RST = ~(RUN_AT_RESET ^ INV_POL);

  logic [NREG-1:0]   set_s, clr_s, rd_sel;
  logic [DATA_W-1:0] word_q [NREG];
  logic [N_LINES-1:0] rst_q, stop_q;

  clkrst_decode #(
    .ADDR_W(ADDR_W), .N_WORDS(N_WORDS), .RST_BASE(RST_BASE), .CLK_BASE(CLK_BASE),
    .WORD_STEP(WORD_STEP), .CLR_OFS(CLR_OFS)
  ) u_dec (
    .req_i(req_i), .we_i(we_i), .addr_i(addr_i),
    .set_o(set_s), .clr_o(clr_s), .rd_sel_o(rd_sel)
  );

  for (genvar g = 0; g < 2; g++) begin : g_grp
    for (genvar w = 0; w < N_WORDS; w++) begin : g_word
      localparam int unsigned K = g * N_WORDS + w;
      localparam logic [DATA_W-1:0] RV =
        (g == int'(GRP_RST)) ? '1 : STOP_RST[w*DATA_W +: DATA_W];
      clkrst_sc_word #(.WIDTH(DATA_W), .RST_VAL(RV)) u_word (
        .clk_i(clk_i), .rst_ni(rst_ni), .set_i(set_s[K]), .clr_i(clr_s[K]),
        .mask_i(wdata_i), .q_o(word_q[K])
      );
      if (g == int'(GRP_RST)) begin : g_r
        assign rst_q[w*DATA_W +: DATA_W] = word_q[K];
      end else begin : g_c
        assign stop_q[w*DATA_W +: DATA_W] = word_q[K];
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    for (int k = 0; k < int'(NREG); k++)
      if (rd_sel[k]) rdata_o = rdata_o | word_q[k];
  end

  assign rst_o    = rst_q;
  assign clk_en_o = ~(stop_q ^ INV_POL);
endmodule

// File: rtl/clkrst_bank_chk.sv
module clkrst_bank_chk #(
  parameter int unsigned N_LINES = 64,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned ADDR_W  = 12,
  parameter logic [ADDR_W-1:0] RST_BASE = 12'h040,
  parameter logic [ADDR_W-1:0] CLK_BASE = 12'h080,
  parameter int unsigned CLR_OFS = 4
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               req_i,
  input logic               we_i,
  input logic [ADDR_W-1:0]  addr_i,
  input logic [DATA_W-1:0]  wdata_i,
  input logic [DATA_W-1:0]  rdata_o,
  input logic [N_LINES-1:0] rst_o,
  input logic [N_LINES-1:0] clk_en_o
);
  localparam logic [ADDR_W-1:0] RST_CLR = RST_BASE + ADDR_W'(CLR_OFS);
  logic wr;
  logic mapped;
  assign wr = req_i && we_i;
  assign mapped = (addr_i[ADDR_W-1:5] == RST_BASE[ADDR_W-1:5] ||
                   addr_i[ADDR_W-1:5] == CLK_BASE[ADDR_W-1:5]) &&
                  (addr_i[1:0] == 2'b00) && (addr_i[3] == 1'b0);

  a_r2_set_lower_rst: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr && addr_i == RST_BASE |=> (rst_o[DATA_W-1:0] & $past(wdata_i)) == $past(wdata_i));

  a_r3_clr_lower_rst: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr && addr_i == RST_CLR |=> (rst_o[DATA_W-1:0] & $past(wdata_i)) == '0);

  a_r4_zero_bits_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr && (addr_i == RST_BASE || addr_i == RST_CLR) |=>
      ((rst_o[DATA_W-1:0] ^ $past(rst_o[DATA_W-1:0])) & ~$past(wdata_i)) == '0);

  a_r7_polarity_bit14: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && !we_i && addr_i == CLK_BASE |->
      rdata_o[14] == clk_en_o[14] && rdata_o[13] != clk_en_o[13]);

  a_r9_unmapped_read_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && !we_i && !mapped |-> rdata_o == '0);

  a_r9_unmapped_write_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr && !mapped |=> $stable(rst_o) && $stable(clk_en_o));

  a_r10_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr |=> $stable(rst_o) && $stable(clk_en_o));
endmodule

bind clkrst_bank clkrst_bank_chk #(
  .N_LINES(N_LINES), .DATA_W(DATA_W), .ADDR_W(ADDR_W),
  .RST_BASE(RST_BASE), .CLK_BASE(CLK_BASE), .CLR_OFS(CLR_OFS)
) u_chk (.*);

// File: tb/clkrst_bank_test.sv
module clkrst_bank_test;
  localparam logic [63:0] CRIT = 64'h0000_0004_0000_0061;
  localparam logic [63:0] INV  = 64'h0000_0000_0000_4000;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 1'b0;
  logic        we_i = 1'b0;
  logic [11:0] addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic [63:0] rst_o, clk_en_o;

  int checks = 0;
  int errors = 0;
  logic [63:0] m_rst, m_stop;

  clkrst_bank uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .we_i(we_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .rst_o(rst_o), .clk_en_o(clk_en_o)
  );

  always #4ns clk_i = ~clk_i;

  initial begin
    #1ms;
    errors++;
    $display("FAIL watchdog: run hung, actual running expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  function automatic logic [63:0] exp_en(logic [63:0] stop);
    logic [63:0] e;
    for (int i = 0; i < 64; i++) e[i] = (i == 14) ? stop[i] : !stop[i];
    return e;
  endfunction

  function automatic logic [31:0] exp_rd(logic [11:0] a);
    case (a)
      12'h040, 12'h044: return m_rst[31:0];
      12'h050, 12'h054: return m_rst[63:32];
      12'h080, 12'h084: return m_stop[31:0];
      12'h090, 12'h094: return m_stop[63:32];
      default:          return 32'h0;
    endcase
  endfunction

  task automatic model_wr(logic [11:0] a, logic [31:0] d);
    case (a)
      12'h040: m_rst[31:0]   |= d;
      12'h044: m_rst[31:0]   &= ~d;
      12'h050: m_rst[63:32]  |= d;
      12'h054: m_rst[63:32]  &= ~d;
      12'h080: m_stop[31:0]  |= d;
      12'h084: m_stop[31:0]  &= ~d;
      12'h090: m_stop[63:32] |= d;
      12'h094: m_stop[63:32] &= ~d;
      default: ;
    endcase
  endtask

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk_i);
    req_i = 1'b1; we_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    req_i = 1'b0; we_i = 1'b0;
    model_wr(a, d);
  endtask

  task automatic rd_chk(string req, logic [11:0] a);
    @(negedge clk_i);
    req_i = 1'b1; we_i = 1'b0; addr_i = a; wdata_i = $urandom;
    #1ns;
    chk(req, {32'h0, rdata_o}, {32'h0, exp_rd(a)});
    @(negedge clk_i);
    req_i = 1'b0;
  endtask

  task automatic out_chk(string req);
    #1ns;
    chk({req, " rst_o"}, rst_o, m_rst);
    chk({req, " clk_en_o"}, clk_en_o, exp_en(m_stop));
  endtask

  initial begin
    logic [11:0] addrs [12] = '{12'h040, 12'h044, 12'h050, 12'h054, 12'h080, 12'h084,
                                12'h090, 12'h094, 12'h048, 12'h042, 12'h0A0, 12'h3FC};
    void'($urandom(32'd1234));
    m_rst = '1;
    m_stop = ~(CRIT ^ INV);
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R1 reset state
    out_chk("R1");
    chk("R1 crit running", clk_en_o, CRIT);
    chk("R8 rst all held", rst_o, '1);
    // R5 index mapping: line 40 is upper word bit 8
    wr(12'h054, 32'h0000_0100);
    chk("R5 line40 released", {63'h0, rst_o[40]}, 64'h0);
    chk("R5 line8 still held", {63'h0, rst_o[8]}, 64'h1);
    // R3 clear and R4 others hold
    wr(12'h044, 32'h0000_00F0);
    out_chk("R3");
    chk("R4 low nibble held", {60'h0, rst_o[3:0]}, 64'hF);
    // R2 set
    wr(12'h040, 32'h0000_0030);
    out_chk("R2");
    // R7 bit 14 inverted: set runs it, line 13 stop
    wr(12'h080, 32'h0000_6000);
    chk("R7 bit14 runs on 1", {63'h0, clk_en_o[14]}, 64'h1);
    chk("R7 bit13 stops on 1", {63'h0, clk_en_o[13]}, 64'h0);
    wr(12'h084, 32'h0000_4000);
    chk("R7 bit14 stopped on 0", {63'h0, clk_en_o[14]}, 64'h0);
    // R6 readback from set and clear alias
    rd_chk("R6 set addr", 12'h080);
    rd_chk("R6 clr alias", 12'h084);
    rd_chk("R6 upper rst", 12'h050);
    // R9 unmapped
    wr(12'h048, 32'hFFFF_FFFF);
    wr(12'h082, 32'hFFFF_FFFF);
    out_chk("R9 write ignored");
    rd_chk("R9 read zero", 12'h0A0);
    rd_chk("R9 misaligned read zero", 12'h041);
    // R10 reads do not change state
    for (int i = 0; i < 4; i++) rd_chk("R10 read", addrs[i*2]);
    out_chk("R10");
    // random mix
    for (int n = 0; n < 400; n++) begin
      logic [11:0] a;
      a = addrs[$urandom_range(11)];
      if ($urandom_range(3) == 0) rd_chk("R6 random read", a);
      else begin
        wr(a, $urandom);
        out_chk("R2 R3 R4 R8 random");
      end
      if ($urandom_range(7) == 0) begin
        @(negedge clk_i);
        out_chk("R10 idle");
      end
    end
    for (int i = 0; i < 12; i++) rd_chk("R6 R9 final read", addrs[i]);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule